// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

The controller collects up to 32 level-sensitive request lines from peripherals and places each one into one of three classes. Requests steered to the fast class merge into a single fast-interrupt line to the processor. Every other enabled request raises the normal-interrupt line. The normal class has two parts. Sixteen vectored slots can each watch any source, and each slot carries its own handler address. A source that no slot watches is non-vectored and shares one default handler address with every other such source.

Software uses a small word-addressed register port. Through it software assigns classes, enables sources, forces requests, fills the slot tables and reads status. A read of the vector register returns the address of the best-ranked active slot and starts a service period. For the rest of that period the served slot and every lower rank are masked. An end-of-service write to the same register clears the mask.

Top module: `vic_top`

## Requirements
- R1: After reset both interrupt outputs are low and all enables, class bits, force bits, slot entries and the default address (offset 0x08) are zero. A vector read made in that state returns 0.
- R2: `fiqOut` is high exactly when some enabled source whose class bit (offset 0x03, 1 = fast) is set has its raw request active.
- R3: The fast status word (offset 0x00) reads back the enabled, active, fast-class sources as one bit per source.
- R4: Slot ranks run from slot 0 (highest) to slot 15 (lowest). When several slots match, the vector read returns the address (offset 0x60+n) of the lowest-numbered matching slot. Any source may sit in any slot.
- R5: A matching vectored slot always beats a non-vectored request. When no slot matches, the vector read (offset 0x07) returns the default address.
- R6: `irqOut` is high when an enabled normal-class request is active and the service mask does not hide it.
- R7: The normal status word (offset 0x01) reads back the enabled, active sources whose class bit is clear.
- R8: Each slot control word (offset 0x40+n) holds the source number in bits 4:0 and the slot enable in bit 5. A slot matches only if it is enabled, its source is enabled and active, and that source is not fast-class.
- R9: Writing offset 0x04 sets the enable of each source whose write bit is 1. Writing offset 0x05 clears them. Bits written as 0 change nothing. Both offsets read back the enable word.
- R10: The raw status word (offset 0x02) equals the request lines ORed with the force word (offset 0x06). All classification uses this raw status ANDed with the enables.
- R11: A vector read that finds slot k masks slots k..15 and the non-vectored requests. A read that finds no slot masks only the non-vectored requests. A read never loosens a mask that is already tighter. Any write to offset 0x07 removes the mask.
- R12: Both interrupt outputs and the read data are registered. Each reflects inputs and register state from the edge before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 32 | Peripheral request lines, level sensitive |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 7 | Word offset of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after the read strobe |
| fiqOut | output | 1 | Fast-interrupt request |
| irqOut | output | 1 | Normal-interrupt request |

## Verification
Each result is due one clock edge after its cause. A change on `reqIn` or a register write reaches `fiqOut` and `irqOut` at the next rising edge. A read strobe returns its data at the edge that samples it, and a vector read updates the service mask at that same edge. The bench drives inputs on falling edges, waits exactly one rising edge, and samples on the falling edge that follows. It keeps its model of the mask and of the registers in step with the same edge, so each expected value is built from the state the design held when it captured.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int REG_AW = 7;

  localparam logic [REG_AW-1:0] OFF_FAST_STAT = 7'h00;
  localparam logic [REG_AW-1:0] OFF_NORM_STAT = 7'h01;
  localparam logic [REG_AW-1:0] OFF_RAW_STAT  = 7'h02;
  localparam logic [REG_AW-1:0] OFF_CLASS     = 7'h03;
  localparam logic [REG_AW-1:0] OFF_EN_SET    = 7'h04;
  localparam logic [REG_AW-1:0] OFF_EN_CLR    = 7'h05;
  localparam logic [REG_AW-1:0] OFF_FORCE     = 7'h06;
  localparam logic [REG_AW-1:0] OFF_VECTOR    = 7'h07;
  localparam logic [REG_AW-1:0] OFF_DEFAULT   = 7'h08;
  localparam logic [1:0]        SLOT_CTL_PAGE  = 2'b10;  // 0x40..0x5F
  localparam logic [1:0]        SLOT_ADDR_PAGE = 2'b11;  // 0x60..0x7F

  typedef enum logic [3:0] {
    RD_ZERO, RD_FAST, RD_NORM, RD_RAW, RD_CLASS, RD_EN,
    RD_FORCE, RD_VEC, RD_DEF, RD_SLOT_CTL, RD_SLOT_ADDR
  } rdSel_e;

  typedef struct packed {
    logic       enSet;
    logic       enClr;
    logic       classWr;
    logic       forceWr;
    logic       defWr;
    logic       slotCtlWr;
    logic       slotAddrWr;
    logic       eoiWr;
    logic       vecRead;
    logic       rdValid;
    logic [4:0] slot;
    rdSel_e     rdSel;
  } vicStrobe_t;

endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  output vicStrobe_t        strb
);

  logic [1:0] page;
  logic [4:0] slotField;
  logic       slotOk;

  assign page      = regAddr[REG_AW-1:REG_AW-2];
  assign slotField = regAddr[4:0];
  assign slotOk    = (int'(slotField) < NUM_SLOTS);

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_ZERO;
    strb.slot   = slotField;
    strb.rdValid = regRdEn;
    if (regWrEn) begin
      unique case (1'b1)
        (regAddr == OFF_CLASS):   strb.classWr = 1'b1;
        (regAddr == OFF_EN_SET):  strb.enSet   = 1'b1;
        (regAddr == OFF_EN_CLR):  strb.enClr   = 1'b1;
        (regAddr == OFF_FORCE):   strb.forceWr = 1'b1;
        (regAddr == OFF_VECTOR):  strb.eoiWr   = 1'b1;
        (regAddr == OFF_DEFAULT): strb.defWr   = 1'b1;
        (page == SLOT_CTL_PAGE):  strb.slotCtlWr  = slotOk;
        (page == SLOT_ADDR_PAGE): strb.slotAddrWr = slotOk;
        default: ;
      endcase
    end
    if (regRdEn) begin
      if (regAddr == OFF_FAST_STAT)      strb.rdSel = RD_FAST;
      else if (regAddr == OFF_NORM_STAT) strb.rdSel = RD_NORM;
      else if (regAddr == OFF_RAW_STAT)  strb.rdSel = RD_RAW;
      else if (regAddr == OFF_CLASS)     strb.rdSel = RD_CLASS;
      else if (regAddr == OFF_EN_SET || regAddr == OFF_EN_CLR) strb.rdSel = RD_EN;
      else if (regAddr == OFF_FORCE)     strb.rdSel = RD_FORCE;
      else if (regAddr == OFF_VECTOR) begin
        strb.rdSel   = RD_VEC;
        strb.vecRead = 1'b1;
      end
      else if (regAddr == OFF_DEFAULT)   strb.rdSel = RD_DEF;
      else if (page == SLOT_CTL_PAGE && slotOk)  strb.rdSel = RD_SLOT_CTL;
      else if (page == SLOT_ADDR_PAGE && slotOk) strb.rdSel = RD_SLOT_ADDR;
    end
  end

  // R9: set and clear never fire together
  a_r9_set_clear_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.enSet && strb.enClr));
  // R11: a service read is only ever raised by a read strobe
  a_r11_vec_read_from_port: assert property (@(posedge clk) disable iff (!rstN)
    strb.vecRead |-> regRdEn);
  a_r11_one_write_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enSet, strb.enClr, strb.classWr, strb.forceWr, strb.defWr,
              strb.slotCtlWr, strb.slotAddrWr, strb.eoiWr}));

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     hits,
  output logic             anyHit,
  output logic [IDX_W-1:0] winIdx
);

  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  // R4: the winner is itself a hit and nothing ranked above it is
  a_r4_winner_is_hit: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> hits[winIdx]);
  a_r4_nothing_above: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> ((hits & ((N'(1) << winIdx) - N'(1))) == '0));

endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int LVL_W  = $clog2(NUM_SLOTS + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  vicStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               fiqOut,
  output logic               irqOut
);

  localparam logic [LVL_W-1:0] LVL_DEFAULT = LVL_W'(NUM_SLOTS);
  localparam logic [LVL_W-1:0] LVL_IDLE    = LVL_W'(NUM_SLOTS + 1);

  logic [NUM_SRC-1:0] enableReg, classReg, forceReg;
  logic [DATA_W-1:0]  defAddr;
  logic               slotEn   [NUM_SLOTS];
  logic [SRC_W-1:0]   slotSrc  [NUM_SLOTS];
  logic [DATA_W-1:0]  slotAddr [NUM_SLOTS];
  logic [LVL_W-1:0]   levelReg;

  logic [NUM_SRC-1:0]   rawStat, maskedStat, fastAct, normAct;
  logic [NUM_SLOTS-1:0] vecHit;
  logic                 anyHit;
  logic [SLOT_W-1:0]    winIdx;
  logic [DATA_W-1:0]    vecValue;
  logic [LVL_W-1:0]     candLevel;
  logic [SLOT_W-1:0]    slotSel;
  logic                 unusedBits;

  assign slotSel    = strb.slot[SLOT_W-1:0];
  assign unusedBits = ^{strb.slot, strb.rdValid};

  assign rawStat    = reqIn | forceReg;
  assign maskedStat = rawStat & enableReg;
  assign fastAct    = maskedStat & classReg;
  assign normAct    = maskedStat & ~classReg;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slotMatch
    assign vecHit[s] = slotEn[s] && normAct[slotSrc[s]] && (LVL_W'(s) < levelReg);
  end

  vic_prio #(.N(NUM_SLOTS)) u_prio (
    .clk    (clk),
    .rstN   (rstN),
    .hits   (vecHit),
    .anyHit (anyHit),
    .winIdx (winIdx)
  );

  assign vecValue  = anyHit ? slotAddr[winIdx] : defAddr;
  assign candLevel = anyHit ? LVL_W'(winIdx) : LVL_DEFAULT;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= '0;
      classReg  <= '0;
      forceReg  <= '0;
      defAddr   <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        slotEn[s]   <= 1'b0;
        slotSrc[s]  <= '0;
        slotAddr[s] <= '0;
      end
    end else begin
      if (strb.enSet)   enableReg <= enableReg | wrData[NUM_SRC-1:0];
      if (strb.enClr)   enableReg <= enableReg & ~wrData[NUM_SRC-1:0];
      if (strb.classWr) classReg  <= wrData[NUM_SRC-1:0];
      if (strb.forceWr) forceReg  <= wrData[NUM_SRC-1:0];
      if (strb.defWr)   defAddr   <= wrData;
      if (strb.slotCtlWr) begin
        slotSrc[slotSel] <= wrData[SRC_W-1:0];
        slotEn[slotSel]  <= wrData[SRC_W];
      end
      if (strb.slotAddrWr) slotAddr[slotSel] <= wrData;
    end
  end

  // service level: tightened by vector reads, released by end of service
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       levelReg <= LVL_IDLE;
    else if (strb.eoiWr)                             levelReg <= LVL_IDLE;
    else if (strb.vecRead && candLevel < levelReg)   levelReg <= candLevel;
  end

  // registered outputs and read data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fiqOut <= 1'b0;
      irqOut <= 1'b0;
      rdData <= '0;
    end else begin
      fiqOut <= |fastAct;
      irqOut <= anyHit || (levelReg == LVL_IDLE && |normAct);
      unique case (strb.rdSel)
        RD_FAST:      rdData <= DATA_W'(fastAct);
        RD_NORM:      rdData <= DATA_W'(normAct);
        RD_RAW:       rdData <= DATA_W'(rawStat);
        RD_CLASS:     rdData <= DATA_W'(classReg);
        RD_EN:        rdData <= DATA_W'(enableReg);
        RD_FORCE:     rdData <= DATA_W'(forceReg);
        RD_VEC:       rdData <= vecValue;
        RD_DEF:       rdData <= defAddr;
        RD_SLOT_CTL:  rdData <= DATA_W'({slotEn[slotSel], slotSrc[slotSel]});
        RD_SLOT_ADDR: rdData <= slotAddr[slotSel];
        default:      rdData <= '0;
      endcase
    end
  end

  // R11: without an end-of-service write the mask only tightens
  a_r11_level_tightens: assert property (@(posedge clk) disable iff (!rstN)
    !strb.eoiWr |=> levelReg <= $past(levelReg));
  a_r11_eoi_release: assert property (@(posedge clk) disable iff (!rstN)
    strb.eoiWr |=> levelReg == LVL_IDLE);
  // R2: the fast line needs a raw request the cycle before
  a_r2_fiq_has_source: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> $past(|(reqIn | forceReg)));
  // R6: the normal line needs a raw request the cycle before
  a_r6_irq_has_source: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|(reqIn | forceReg)));
  // R8: a fast-class source is never a vectored winner
  a_r8_fast_not_vectored: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> !classReg[slotSrc[winIdx]]);

endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               fiqOut,
  output logic               irqOut
);

  vicStrobe_t strb;

  vic_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  vic_datapath #(
    .NUM_SRC   (NUM_SRC),
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .reqIn  (reqIn),
    .strb   (strb),
    .wrData (regWrData),
    .rdData (regRdData),
    .fiqOut (fiqOut),
    .irqOut (irqOut)
  );

endmodule

// File: tb/vic_top_test.sv
`timescale 1ns/1ps
module vic_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] reqIn = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        fiqOut, irqOut;

  always #2 clk = ~clk;

  vic_top uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .fiqOut(fiqOut), .irqOut(irqOut)
  );

  // reference model state
  logic [31:0] mEn = '0, mCls = '0, mForce = '0, mDef = '0;
  logic        mSlotEn [16];
  logic [4:0]  mSlotSrc [16];
  logic [31:0] mSlotAddr [16];
  int          mLvl = 17;
  logic [31:0] lastExpVec;
  int nChecks = 0, nFails = 0;

  function automatic logic [31:0] mNorm();
    return (reqIn | mForce) & mEn & ~mCls;
  endfunction
  function automatic logic [31:0] mFast();
    return (reqIn | mForce) & mEn & mCls;
  endfunction
  function automatic int bestSlot();
    logic [31:0] n = mNorm();
    for (int i = 0; i < 16; i++)
      if (i < mLvl && mSlotEn[i] && n[mSlotSrc[i]]) return i;
    return -1;
  endfunction
  function automatic logic expIrq();
    return (bestSlot() >= 0) || (mLvl == 17 && |mNorm());
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    if (a == 7'h03) mCls = d;
    else if (a == 7'h04) mEn = mEn | d;
    else if (a == 7'h05) mEn = mEn & ~d;
    else if (a == 7'h06) mForce = d;
    else if (a == 7'h07) mLvl = 17;
    else if (a == 7'h08) mDef = d;
    else if (a[6:4] == 3'b100) begin mSlotSrc[a[3:0]] = d[4:0]; mSlotEn[a[3:0]] = d[5]; end
    else if (a[6:4] == 3'b110) mSlotAddr[a[3:0]] = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    int b;
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    if (a == 7'h07) begin
      b = bestSlot();
      lastExpVec = (b >= 0) ? mSlotAddr[b] : mDef;
      if (b < 0) b = 16;
    end
    @(posedge clk);
    if (a == 7'h07 && b < mLvl) mLvl = b;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic vecCheck(string tag);
    logic [31:0] d;
    rd(7'h07, d);
    check(tag, d, lastExpVec);
  endtask

  task automatic setReq(logic [31:0] r);
    @(negedge clk);
    reqIn = r;
  endtask

  task automatic outCheck(string tag);
    @(posedge clk);
    @(negedge clk);
    check({tag, " fiq"}, 32'(fiqOut), 32'(|mFast()));
    check({tag, " irq"}, 32'(irqOut), 32'(expIrq()));
  endtask

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int seed;
    for (int i = 0; i < 16; i++) begin
      mSlotEn[i] = 1'b0; mSlotSrc[i] = '0; mSlotAddr[i] = '0;
    end
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 fiq", 32'(fiqOut), 0);
    check("R1 irq", 32'(irqOut), 0);
    rd(7'h04, d); check("R1 enables", d, 0);
    vecCheck("R1 vector");
    check("R1 vector zero", lastExpVec, 0);
    wr(7'h07, 0);

    // R9: write-one set and clear
    wr(7'h04, 32'h0000_00F0); rd(7'h04, d); check("R9 set", d, 32'h0000_00F0);
    wr(7'h04, 32'h0000_0003); rd(7'h04, d); check("R9 set keeps", d, 32'h0000_00F3);
    wr(7'h05, 32'h0000_0010); rd(7'h05, d); check("R9 clear", d, 32'h0000_00E3);
    wr(7'h05, 32'h0);         rd(7'h04, d); check("R9 clear zero", d, 32'h0000_00E3);
    wr(7'h04, 32'h0);         rd(7'h04, d); check("R9 set zero", d, 32'h0000_00E3);

    // R10: raw status combines force
    setReq(32'h4);
    wr(7'h06, 32'h1);
    rd(7'h02, d); check("R10 raw", d, 32'h5);
    wr(7'h06, 32'h0);
    setReq(32'h0);
    outCheck("R10 idle");

    // R2, R3: fast class
    wr(7'h03, 32'h3);
    setReq(32'h2);
    outCheck("R2 fast");
    rd(7'h00, d); check("R3 fast status", d, 32'h2);
    wr(7'h05, 32'h2);
    outCheck("R2 disabled");
    wr(7'h04, 32'h2);

    // slot setup
    wr(7'h08, 32'hD000_0000);
    wr(7'h43, 32'h25); wr(7'h63, 32'h1000_0300);
    wr(7'h47, 32'h26); wr(7'h67, 32'h0000_0700);
    wr(7'h40, 32'h21); wr(7'h60, 32'h0000_0100);
    wr(7'h04, 32'hE0);

    // R12: output timing, R6 irq from non-vectored
    setReq(32'h80);
    #1 check("R12 before edge", 32'(irqOut), 0);
    outCheck("R6 nonvec");
    rd(7'h01, d); check("R7 normal status", d, 32'h80);
    vecCheck("R5 default");
    outCheck("R11 default mask");
    wr(7'h07, 0);
    setReq(32'hC0);
    vecCheck("R5 vectored over default");
    wr(7'h07, 0);
    setReq(32'hE0);
    vecCheck("R4 lowest slot");
    check("R4 addr", lastExpVec, 32'h1000_0300);
    outCheck("R11 masked");
    setReq(32'hE2);
    outCheck("R8 fast source in slot");
    wr(7'h41, 32'h28); wr(7'h61, 32'h0000_0180); wr(7'h04, 32'h100);
    setReq(32'h1E0);
    outCheck("R11 preempt");
    vecCheck("R11 preempt vector");
    check("R11 preempt addr", lastExpVec, 32'h0000_0180);
    wr(7'h07, 0);
    outCheck("R11 release");
    wr(7'h43, 32'h05);
    setReq(32'h60);
    vecCheck("R8 slot disabled");
    wr(7'h07, 0);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) setReq($urandom & $urandom);
      else if (op == 4) begin
        int s = $urandom_range(0, 15);
        wr(7'h40 + 7'(s), 32'($urandom_range(0, 63)));
      end
      else if (op == 5) begin
        int s = $urandom_range(0, 15);
        wr(7'h60 + 7'(s), $urandom);
      end
      else if (op == 6) wr(($urandom & 1) ? 7'h04 : 7'h05, $urandom);
      else if (op == 7) wr(7'h03, $urandom & $urandom & $urandom);
      else if (op == 8) vecCheck("R4 R5 R11 random vector");
      else wr(7'h07, 0);
      outCheck("R2 R6 random");
      if (op == 0) begin
        rd(7'h01, d); check("R7 random normal", d, mNorm());
        rd(7'h00, d); check("R3 random fast", d, mFast());
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule